// File: doc/BRIEF.md
# Exception Entry Sequencer

This block is the control slice of a 32-bit RISC core that steers the core into an exception. It covers three entries: reset release, fast interrupt and normal interrupt. The two interrupt request lines arrive asynchronously and pass through a flop synchroniser. Pending, unmasked requests are arbitrated with the fast interrupt winning. The winning entry starts only when the pipeline reports an instruction boundary.

An entry takes two cycles. In the first cycle the block writes the return PC into the banked link register of the target mode and the old status word into that mode's saved status register. In the second cycle it writes the new status word and redirects instruction fetch to the entry vector. While reset is held low the block tells the pipeline to abandon its current instruction. During that time it issues no redirect, so fetch keeps stepping through word addresses.

Status-word bit positions used throughout: mode M[4:0] in bits 4:0, T (Thumb state) in bit 5, F (fast interrupt mask) in bit 6, I (interrupt mask) in bit 7.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, `abandon` is 1 and `lr_we`, `spsr_we`, `cpsr_we` and `redirect` are all 0.
- R2: At the first clock edge with `rst_n` high, the block captures `cur_pc` and `cur_cpsr`. One cycle after that edge it writes them to the link and saved status registers with `bank_mode` = 5'b10011. One cycle later it writes a status word that keeps the other bits of the captured value but has mode 5'b10011, I=1, F=1 and T=0, and it redirects fetch to 0x00.
- R3: Fast interrupt entry saves PC and status word into the 5'b10001 banks. It then writes a status word with mode 5'b10001, I=1, F=1 and T=0, and redirects to 0x1C.
- R4: Normal interrupt entry saves into the 5'b10010 banks. It then writes a status word with mode 5'b10010, I=1, T=0 and F unchanged, and redirects to 0x18.
- R5: When both requests are pending and unmasked, the fast interrupt is taken.
- R6: A fast request is ignored while F=1, and a normal request is ignored while I=1. No write and no redirect occur.
- R7: An entry starts only at a clock edge where `insn_done` is 1. With a synchronised request pending, `redirect` rises two edges after the edge that samples `insn_done` high.
- R8: With `insn_done` held high, a request first sampled at edge k gives `redirect` after edge k+3, that is 4 edges. This stays within the bound of 4 to 5 edges.
- R9: In every entry, the link/saved-status write lasts exactly one cycle and is immediately followed by exactly one cycle of status write with redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fiq_req | input | 1 | Asynchronous fast interrupt request, active high |
| irq_req | input | 1 | Asynchronous normal interrupt request, active high |
| insn_done | input | 1 | Instruction boundary strobe |
| cur_pc | input | 32 | Current return PC |
| cur_cpsr | input | 32 | Current status word |
| abandon | output | 1 | Discard the executing instruction (reset held) |
| lr_we | output | 1 | Banked link register write enable |
| lr_data | output | 32 | Link register write data |
| spsr_we | output | 1 | Saved status register write enable |
| spsr_data | output | 32 | Saved status register write data |
| bank_mode | output | 5 | Mode whose banks receive the writes |
| cpsr_we | output | 1 | Status word write enable |
| cpsr_data | output | 32 | New status word |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | 32 | Vector address for the redirect |

## Verification
Each result has a fixed due cycle. The bank write appears one edge after the edge that starts the entry, and the status write with redirect appears one edge after that. A request therefore reaches the vector four edges after its first sampling edge: two synchroniser stages plus the two entry cycles. The bench drives inputs on the falling edge and counts rising edges until `redirect` is seen on a falling edge. It records the bank write seen on the falling edge just before the redirect and compares every count and value against these offsets. Masking and boundary-wait cases watch the ports for a fixed window long enough to cover the full latency.

// File: rtl/exc_pkg.sv
// Package: shared constants and types of the exception entry sequencer.
// Assumes the status-word layout M[4:0], T=bit5, F=bit6, I=bit7.
package exc_pkg;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned MODE_W = 5;
    localparam int unsigned BIT_T  = 5;
    localparam int unsigned BIT_F  = 6;
    localparam int unsigned BIT_I  = 7;

    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;

    localparam logic [XLEN-1:0] VEC_RESET = 32'h0000_0000;
    localparam logic [XLEN-1:0] VEC_IRQ   = 32'h0000_0018;
    localparam logic [XLEN-1:0] VEC_FIQ   = 32'h0000_001C;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_IDLE = 2'd1,
        ST_SAVE = 2'd2,
        ST_VECT = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_RESET = 2'd0,
        KIND_FIQ   = 2'd1,
        KIND_IRQ   = 2'd2
    } exc_kind_e;
endpackage

// File: rtl/exc_sync.sv
// Module: multi-stage flop synchroniser for a bundle of asynchronous lines.
// Assumes each line is a level that stays asserted until serviced.
module exc_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Stage 0 samples the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    // Remaining stages shift the sample along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/exc_arb.sv
// Module: masks and prioritises synchronised interrupt requests.
// Assumes the masks are the live status-word I and F bits; FIQ wins ties.
module exc_arb (
    input  logic fiq_sync,
    input  logic irq_sync,
    input  logic f_mask,
    input  logic i_mask,
    input  logic boundary,
    output logic take,
    output logic take_fiq
);
    logic fiq_ok;
    logic irq_ok;

    // Qualify each request with its mask, then pick by fixed priority.
    always_comb begin
        fiq_ok   = fiq_sync && !f_mask;
        irq_ok   = irq_sync && !i_mask;
        take     = boundary && (fiq_ok || irq_ok);
        take_fiq = fiq_ok;
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Module: exception entry sequencer (top). Runs the two-cycle entry for
// reset release, FIQ and IRQ: bank writes first, then status write and
// fetch redirect. Assumes the pipeline applies the writes at the clock edge.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fiq_req,
    input  logic            irq_req,
    input  logic            insn_done,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_cpsr,
    output logic            abandon,
    output logic            lr_we,
    output logic [XLEN-1:0] lr_data,
    output logic            spsr_we,
    output logic [XLEN-1:0] spsr_data,
    output logic [MODE_W-1:0] bank_mode,
    output logic            cpsr_we,
    output logic [XLEN-1:0] cpsr_data,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_addr
);
    localparam int unsigned NREQ = 2;

    logic [NREQ-1:0] req_sync;
    logic            take;
    logic            take_fiq;
    seq_state_e      state_q;
    exc_kind_e       kind_q;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] psr_q;
    logic [MODE_W-1:0] tgt_mode;
    logic [XLEN-1:0]   tgt_vec;

    exc_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({fiq_req, irq_req}),
        .sync_out (req_sync)
    );

    exc_arb u_arb (
        .fiq_sync (req_sync[1]),
        .irq_sync (req_sync[0]),
        .f_mask   (cur_cpsr[BIT_F]),
        .i_mask   (cur_cpsr[BIT_I]),
        .boundary (insn_done && state_q == ST_IDLE),
        .take     (take),
        .take_fiq (take_fiq)
    );

    // Sequencer state, entry kind and captured PC/status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            kind_q  <= KIND_RESET;
            pc_q    <= '0;
            psr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    state_q <= ST_SAVE;
                    kind_q  <= KIND_RESET;
                    pc_q    <= cur_pc;
                    psr_q   <= cur_cpsr;
                end
                ST_IDLE: begin
                    if (take) begin
                        state_q <= ST_SAVE;
                        kind_q  <= take_fiq ? KIND_FIQ : KIND_IRQ;
                        pc_q    <= cur_pc;
                        psr_q   <= cur_cpsr;
                    end
                end
                ST_SAVE: state_q <= ST_VECT;
                ST_VECT: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Target mode and vector for the entry in progress.
    always_comb begin
        unique case (kind_q)
            KIND_FIQ: begin tgt_mode = MODE_FIQ; tgt_vec = VEC_FIQ;   end
            KIND_IRQ: begin tgt_mode = MODE_IRQ; tgt_vec = VEC_IRQ;   end
            default:  begin tgt_mode = MODE_SVC; tgt_vec = VEC_RESET; end
        endcase
    end

    // Output strobes and data from the current state.
    always_comb begin
        abandon       = !rst_n;
        lr_we         = rst_n && state_q == ST_SAVE;
        spsr_we       = lr_we;
        lr_data       = pc_q;
        spsr_data     = psr_q;
        bank_mode     = tgt_mode;
        cpsr_we       = rst_n && state_q == ST_VECT;
        redirect      = cpsr_we;
        redirect_addr = tgt_vec;
        cpsr_data              = psr_q;
        cpsr_data[MODE_W-1:0]  = tgt_mode;
        cpsr_data[BIT_T]       = 1'b0;
        cpsr_data[BIT_I]       = 1'b1;
        if (kind_q != KIND_IRQ) cpsr_data[BIT_F] = 1'b1;
    end

    AST_WRITE_THEN_VECT: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |=> (redirect && cpsr_we && !lr_we)); // R9
    AST_VECT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(lr_we)); // R9
    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_we |-> (cpsr_data[BIT_I] && !cpsr_data[BIT_T])); // R2
    AST_FIQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && cpsr_data[MODE_W-1:0] == MODE_FIQ) |-> (redirect_addr == VEC_FIQ && cpsr_data[BIT_F])); // R3
    AST_IRQ_KEEPS_F: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && redirect_addr == VEC_IRQ) |-> (cpsr_data[BIT_F] == $past(spsr_data[BIT_F]))); // R4
endmodule

// File: tb/exc_entry_seq_tb.sv
// Bench: directed scenario tasks, each checking its own results.
module exc_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fiq_req = 1'b0;
    logic        irq_req = 1'b0;
    logic        insn_done = 1'b1;
    logic [31:0] cur_pc = 32'h0;
    logic [31:0] cur_cpsr = 32'h0;
    logic        abandon, lr_we, spsr_we, cpsr_we, redirect;
    logic [31:0] lr_data, spsr_data, cpsr_data, redirect_addr;
    logic [4:0]  bank_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .fiq_req(fiq_req), .irq_req(irq_req),
        .insn_done(insn_done), .cur_pc(cur_pc), .cur_cpsr(cur_cpsr),
        .abandon(abandon), .lr_we(lr_we), .lr_data(lr_data),
        .spsr_we(spsr_we), .spsr_data(spsr_data), .bank_mode(bank_mode),
        .cpsr_we(cpsr_we), .cpsr_data(cpsr_data), .redirect(redirect),
        .redirect_addr(redirect_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive a request pattern and follow the entry to its redirect.
    task automatic run_entry(input string tag, input logic [31:0] pc, input logic [31:0] psr,
                             input logic f, input logic i, input logic [31:0] exp_vec,
                             input logic [31:0] exp_psr, input logic [4:0] exp_mode);
        int lat = 0;
        logic [31:0] got_lr = '0, got_sp = '0;
        logic [4:0]  got_bm = '0;
        logic        seen_w = 1'b0;
        cur_pc = pc; cur_cpsr = psr; fiq_req = f; irq_req = i;
        while (lat < 20) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (redirect) break;
            seen_w = lr_we && spsr_we;
            got_lr = lr_data; got_sp = spsr_data; got_bm = bank_mode;
        end
        check({tag, " R8 latency"}, lat, 4);
        check({tag, " R9 bank write before vector"}, {31'd0, seen_w}, 1);
        check({tag, " lr"}, got_lr, pc);
        check({tag, " spsr"}, got_sp, psr);
        check({tag, " bank_mode"}, {27'd0, got_bm}, {27'd0, exp_mode});
        check({tag, " vector"}, redirect_addr, exp_vec);
        check({tag, " new cpsr"}, cpsr_data, exp_psr);
        fiq_req = 1'b0; irq_req = 1'b0; cur_cpsr = cpsr_data;
        @(posedge clk); @(negedge clk);
        check({tag, " R9 single redirect"}, {31'd0, redirect}, 0);
        repeat (4) @(negedge clk);
    endtask

    // Hold a masked request and expect no activity.
    task automatic masked(input string tag, input logic [31:0] psr, input logic f, input logic i);
        int hits = 0;
        cur_cpsr = psr; fiq_req = f; irq_req = i;
        repeat (10) begin
            @(negedge clk);
            if (redirect || lr_we || cpsr_we) hits++;
        end
        check({tag, " R6 masked request ignored"}, hits, 0);
        fiq_req = 1'b0; irq_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check("R1 abandon", {31'd0, abandon}, 1);
        check("R1 no writes", {28'd0, lr_we, spsr_we, cpsr_we, redirect}, 0);
        cur_pc = 32'h0000_0100; cur_cpsr = 32'hA000_0030;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 lr write", {31'd0, lr_we}, 1);
        check("R2 lr data", lr_data, 32'h0000_0100);
        check("R2 spsr data", spsr_data, 32'hA000_0030);
        check("R2 bank mode", {27'd0, bank_mode}, 32'h13);
        @(negedge clk);
        check("R2 redirect", {31'd0, redirect}, 1);
        check("R2 vector", redirect_addr, 32'h0);
        check("R2 new cpsr", cpsr_data, 32'hA000_00D3);
        cur_cpsr = 32'h0000_0010;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_boundary_wait();
        int lat = 0;
        cur_cpsr = 32'h0000_0010; insn_done = 1'b0; fiq_req = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (redirect || lr_we) lat++;
        end
        check("R7 no entry without boundary", lat, 0);
        insn_done = 1'b1; lat = 0;
        while (lat < 10) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (redirect) break;
        end
        check("R7 redirect two edges after boundary", lat, 2);
        check("R7 vector", redirect_addr, 32'h1C);
        fiq_req = 1'b0; cur_cpsr = cpsr_data;
        repeat (5) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        run_entry("R3 fiq", 32'h0000_2000, 32'h2000_0010, 1'b1, 1'b0, 32'h1C, 32'h2000_00D1, 5'h11);
        cur_cpsr = 32'h0000_0010;
        run_entry("R4 irq F kept 1", 32'h0000_3000, 32'h0000_0050, 1'b0, 1'b1, 32'h18, 32'h0000_00D2, 5'h12);
        cur_cpsr = 32'h0000_0010;
        run_entry("R4 irq F kept 0", 32'h0000_3100, 32'h0000_0030, 1'b0, 1'b1, 32'h18, 32'h0000_0092, 5'h12);
        run_entry("R5 both pending", 32'h0000_4000, 32'h4000_0010, 1'b1, 1'b1, 32'h1C, 32'h4000_00D1, 5'h11);
        masked("R6 F set", 32'h0000_0050, 1'b1, 1'b0);
        masked("R6 I set", 32'h0000_0090, 1'b0, 1'b1);
        test_boundary_wait();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule